// File: doc/BRIEF.md
# Oscillator-Aware Core Reset Hold Timer

This block keeps a processor core in reset for a set number of ticks after any reset event, so that the supply and the clock source have time to settle before code runs. The ticks come from a free-running slow timebase, which reaches the block as a one-cycle enable `tick_en` in the fast clock domain. The power-on reset clears everything and is synchronised inside the block. An external reset pin (already synchronised, active low), a watchdog expiry that happens during sleep, and a pin-change wake event all start a new hold period.

How long the core is held depends on two things: whether the device has already completed a hold period since power-on, and which oscillator family is selected. The first period after power-on always uses the long delay. Later periods use the short delay only for oscillator sources that need no start-up time. Every other source gets the long delay again. A flag reports whether the most recent period is the first one since power-on.

Top module: `core_hold_timer`

## Requirements
- R1: While `por_n` is low, `core_rst` is 1 and `first_seq` is 1 (asynchronously). `por_n` is released through a two-stage synchroniser. The first hold period loads on the third rising clock edge after `por_n` rises, provided `ext_rst_n` is high.
- R2: The hold period that follows power-on lasts LONG_TICKS counted ticks, whatever `osc_mode` holds.
- R3: Later hold periods last SHORT_TICKS ticks when `osc_mode` is 3 (external clock), 4 (internal RC) or 5 (external RC). They last LONG_TICKS when `osc_mode` is 0 (low-power crystal), 1 (crystal) or 2 (high-speed crystal).
- R4: The codes 6 and 7 on `osc_mode` select LONG_TICKS.
- R5: While `ext_rst_n` is low, `core_rst` is 1 from the next edge onwards and no ticks are counted. The load happens on the first edge at which the pin is sampled high again.
- R6: A cycle with `wdt_sleep_to` high loads a new hold period on that edge, and `core_rst` is 1 from that edge.
- R7: A cycle with `pin_wake` high loads a new hold period on that edge, and `core_rst` is 1 from that edge.
- R8: Any reset event during a running hold period restarts the count from zero. The period that was interrupted never releases the core, and the core is released only after a cycle with no event.
- R9: Only edges with `tick_en` high advance the count. `core_rst` falls on the edge that carries the final tick, with the load edge counting as zero.
- R10: `first_seq` is 1 for the hold period that follows power-on and stays 1 after that period releases the core. It is 0 for every later period. Only power-on reset sets it back to 1. A period that is cut short does not complete the first period.
- R11: `osc_mode` is sampled on the load edge. Changing it while counting does not change the length of that period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast system clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous assert |
| tick_en | input | 1 | One-cycle tick from the slow free-running timebase |
| ext_rst_n | input | 1 | Synchronised external reset pin, active low |
| wdt_sleep_to | input | 1 | Watchdog expiry while sleeping, one-cycle event |
| pin_wake | input | 1 | Pin-change wake event, one-cycle event |
| osc_mode | input | 3 | Oscillator family code (0..5 defined, 6..7 treated as long) |
| core_rst | output | 1 | Reset to the core, 1 while the hold period runs |
| first_seq | output | 1 | 1 when the latest hold period is the first since power-on |

## Verification
The bench aims at the transitions between delay lengths. A design that fixed the flag too early would give the first period after power-on a short delay in an internal-RC mode. A design that never latched it would keep using the long delay for good. The bench restarts a period partway through with a wake pulse and again with the reset pin. A counter that did not reload would release early, and one that released the interrupted period would produce an extra release with no matching item in the queue. It also changes the oscillator code while a period is counting, runs the count with sparse ticks to catch a counter that advances on raw clock edges, and tries the undefined codes 6 and 7, which must fall back to the long delay.

// File: rtl/core_hold_pkg.sv
package core_hold_pkg;

  typedef enum logic [2:0] {
    OSC_LPXTAL = 3'd0,
    OSC_XTAL   = 3'd1,
    OSC_HSXTAL = 3'd2,
    OSC_EXTCLK = 3'd3,
    OSC_INTRC  = 3'd4,
    OSC_EXTRC  = 3'd5
  } osc_code_t;

  typedef enum logic [1:0] {
    ST_PIN_HOLD = 2'd0,
    ST_COUNTING = 2'd1,
    ST_RELEASED = 2'd2
  } hold_state_t;

  // Sources that are stable at once and can take the short delay.
  function automatic logic osc_is_quick(input logic [2:0] code);
    case (code)
      OSC_EXTCLK, OSC_INTRC, OSC_EXTRC: osc_is_quick = 1'b1;
      default:                          osc_is_quick = 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/core_hold_rst_sync.sv
module core_hold_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);

  logic [STAGES-1:0] chain_q;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_head
      always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) chain_q[0] <= 1'b0;
        else         chain_q[0] <= 1'b1;
      end
    end else begin : g_tail
      always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) chain_q[i] <= 1'b0;
        else         chain_q[i] <= chain_q[i-1];
      end
    end
  end

  assign srst_n = chain_q[STAGES-1];

endmodule

// File: rtl/core_hold_evt_merge.sv
module core_hold_evt_merge #(
  parameter int EVT_N = 2
) (
  input  logic             pin_rst_n,
  input  logic [EVT_N-1:0] evt_i,
  output logic             hold_pin_o,
  output logic             restart_o
);

  assign hold_pin_o = ~pin_rst_n;
  assign restart_o  = |evt_i;

endmodule

// File: rtl/core_hold_len_sel.sv
module core_hold_len_sel
  import core_hold_pkg::*;
(
  input  logic [2:0] osc_mode_i,
  input  logic       boot_done_i,
  output logic       long_sel_o
);

  always_comb begin
    if (!boot_done_i) long_sel_o = 1'b1;
    else              long_sel_o = ~osc_is_quick(osc_mode_i);
  end

endmodule

// File: rtl/core_hold_counter.sv
module core_hold_counter #(
  parameter int LONG_TICKS  = 18000,
  parameter int SHORT_TICKS = 10,
  parameter int CNT_W       = 15
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load_i,
  input  logic long_i,
  input  logic run_i,
  input  logic tick_i,
  output logic expire_o
);

  localparam logic [CNT_W-1:0] LONG_LAST  = CNT_W'(LONG_TICKS - 1);
  localparam logic [CNT_W-1:0] SHORT_LAST = CNT_W'(SHORT_TICKS - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             long_q, long_d;
  logic [CNT_W-1:0] last_val;

  assign last_val = long_q ? LONG_LAST : SHORT_LAST;
  assign expire_o = run_i & tick_i & (cnt_q == last_val);

  always_comb begin
    cnt_d  = cnt_q;
    long_d = long_q;
    if (load_i) begin
      cnt_d  = '0;
      long_d = long_i;
    end else if (run_i && tick_i) begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      long_q <= 1'b1;
    end else begin
      cnt_q  <= cnt_d;
      long_q <= long_d;
    end
  end

endmodule

// File: rtl/core_hold_seq_ctrl.sv
module core_hold_seq_ctrl
  import core_hold_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic hold_pin_i,
  input  logic restart_i,
  input  logic expire_i,
  output logic load_o,
  output logic run_o,
  output logic boot_done_o,
  output logic core_rst_o,
  output logic first_seq_o
);

  hold_state_t state_q, state_d;
  logic        boot_done_q, boot_done_d;
  logic        first_q, first_d;

  always_comb begin
    state_d     = state_q;
    boot_done_d = boot_done_q;
    first_d     = first_q;
    load_o      = 1'b0;
    run_o       = 1'b0;
    if (hold_pin_i) begin
      state_d = ST_PIN_HOLD;
    end else if (restart_i) begin
      state_d = ST_COUNTING;
      load_o  = 1'b1;
    end else begin
      case (state_q)
        ST_PIN_HOLD: begin
          state_d = ST_COUNTING;
          load_o  = 1'b1;
        end
        ST_COUNTING: begin
          run_o = 1'b1;
          if (expire_i) begin
            state_d     = ST_RELEASED;
            boot_done_d = 1'b1;
          end
        end
        default: state_d = ST_RELEASED;
      endcase
    end
    if (load_o) first_d = ~boot_done_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_PIN_HOLD;
      boot_done_q <= 1'b0;
      first_q     <= 1'b1;
    end else begin
      state_q     <= state_d;
      boot_done_q <= boot_done_d;
      first_q     <= first_d;
    end
  end

  assign boot_done_o = boot_done_q;
  assign core_rst_o  = (state_q != ST_RELEASED);
  assign first_seq_o = first_q;

endmodule

// File: rtl/core_hold_timer.sv
module core_hold_timer #(
  parameter int LONG_TICKS  = 18000,
  parameter int SHORT_TICKS = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       por_n,
  input  logic       tick_en,
  input  logic       ext_rst_n,
  input  logic       wdt_sleep_to,
  input  logic       pin_wake,
  input  logic [2:0] osc_mode,
  output logic       core_rst,
  output logic       first_seq
);

  localparam int CNT_W = $clog2(LONG_TICKS + 1);

  logic rst_sync_n;
  logic hold_pin, restart;
  logic load, run, expire, boot_done, long_sel;

  core_hold_rst_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .arst_n (por_n),
    .srst_n (rst_sync_n)
  );

  core_hold_evt_merge #(.EVT_N(2)) u_merge (
    .pin_rst_n  (ext_rst_n),
    .evt_i      ({pin_wake, wdt_sleep_to}),
    .hold_pin_o (hold_pin),
    .restart_o  (restart)
  );

  core_hold_len_sel u_len (
    .osc_mode_i  (osc_mode),
    .boot_done_i (boot_done),
    .long_sel_o  (long_sel)
  );

  core_hold_counter #(
    .LONG_TICKS  (LONG_TICKS),
    .SHORT_TICKS (SHORT_TICKS),
    .CNT_W       (CNT_W)
  ) u_cnt (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .load_i   (load),
    .long_i   (long_sel),
    .run_i    (run),
    .tick_i   (tick_en),
    .expire_o (expire)
  );

  core_hold_seq_ctrl u_ctrl (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .hold_pin_i  (hold_pin),
    .restart_i   (restart),
    .expire_i    (expire),
    .load_o      (load),
    .run_o       (run),
    .boot_done_o (boot_done),
    .core_rst_o  (core_rst),
    .first_seq_o (first_seq)
  );

endmodule

module core_hold_chk (
  input logic clk,
  input logic rst_ok,
  input logic tick_en,
  input logic ext_rst_n,
  input logic wdt_sleep_to,
  input logic pin_wake,
  input logic core_rst,
  input logic first_seq
);

  // R5
  pin_hold_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    !ext_rst_n |=> core_rst);

  // R6
  wdt_restart_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    wdt_sleep_to |=> core_rst);

  // R7
  wake_restart_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    pin_wake |=> core_rst);

  // R9
  release_tick_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    $fell(core_rst) |-> $past(tick_en));

  // R8
  release_quiet_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    $fell(core_rst) |-> ($past(ext_rst_n) && !$past(wdt_sleep_to) && !$past(pin_wake)));

  // R10
  first_sticky_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    !$rose(first_seq));

endmodule

bind core_hold_timer core_hold_chk u_chk (
  .clk          (clk),
  .rst_ok       (rst_sync_n),
  .tick_en      (tick_en),
  .ext_rst_n    (ext_rst_n),
  .wdt_sleep_to (wdt_sleep_to),
  .pin_wake     (pin_wake),
  .core_rst     (core_rst),
  .first_seq    (first_seq)
);

// File: tb/core_hold_timer_tb.sv
`timescale 1ns/1ps
module core_hold_timer_tb;

  localparam int LONG_T  = 40;
  localparam int SHORT_T = 6;

  logic       clk = 1'b0;
  logic       por_n = 1'b0;
  logic       tick_en = 1'b1;
  logic       ext_rst_n = 1'b1;
  logic       wdt_sleep_to = 1'b0;
  logic       pin_wake = 1'b0;
  logic [2:0] osc_mode = 3'd4;
  logic       core_rst;
  logic       first_seq;

  always #2.5 clk = ~clk;

  core_hold_timer #(
    .LONG_TICKS  (LONG_T),
    .SHORT_TICKS (SHORT_T),
    .SYNC_STAGES (2)
  ) u_dut (
    .clk          (clk),
    .por_n        (por_n),
    .tick_en      (tick_en),
    .ext_rst_n    (ext_rst_n),
    .wdt_sleep_to (wdt_sleep_to),
    .pin_wake     (pin_wake),
    .osc_mode     (osc_mode),
    .core_rst     (core_rst),
    .first_seq    (first_seq)
  );

  typedef struct {
    int    ticks;
    bit    first;
    string tag;
  } exp_t;

  exp_t  sb_q[$];
  int    checks = 0;
  int    errors = 0;
  int    mon_cnt = -1;
  int    por_age = 0;
  logic  prev_rst = 1'b1;
  bit    sparse = 1'b0;
  int    cyc = 0;

  function automatic int exp_len(input logic [2:0] m, input bit first);
    if (first) return LONG_T;
    case (m)
      3'd3, 3'd4, 3'd5: return SHORT_T;
      default:          return LONG_T;
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  // tick source
  initial forever begin
    @(negedge clk);
    cyc++;
    tick_en = sparse ? (cyc % 3 == 0) : 1'b1;
  end

  // reference tick counter, from inputs only
  initial forever begin
    @(posedge clk);
    if (!por_n) begin
      mon_cnt = -1;
      por_age = 0;
    end else if (por_age < 2) begin
      por_age++;
      mon_cnt = -1;
    end else if (!ext_rst_n) mon_cnt = -1;
    else if (wdt_sleep_to || pin_wake) mon_cnt = 0;
    else if (mon_cnt == -1) mon_cnt = 0;
    else if (tick_en) mon_cnt++;
  end

  // scoreboard monitor
  initial forever begin
    @(negedge clk);
    if (prev_rst === 1'b1 && core_rst === 1'b0) begin
      if (sb_q.size() == 0) begin
        chk(1'b0, "R8", "release with nothing expected", mon_cnt, -1);
      end else begin
        exp_t e;
        e = sb_q.pop_front();
        chk(mon_cnt == e.ticks, e.tag, "hold length in ticks", mon_cnt, e.ticks);
        chk(first_seq == e.first, "R10", "first_seq at release", int'(first_seq), int'(e.first));
      end
    end
    prev_rst = core_rst;
  end

  task automatic push(input int ticks, input bit first, input string tag);
    exp_t e;
    e.ticks = ticks;
    e.first = first;
    e.tag   = tag;
    sb_q.push_back(e);
  endtask

  task automatic evt(input bit wake, input bit do_push, input string tag);
    @(negedge clk);
    if (do_push) push(exp_len(osc_mode, 1'b0), 1'b0, tag);
    if (wake) pin_wake = 1'b1;
    else      wdt_sleep_to = 1'b1;
    @(negedge clk);
    pin_wake     = 1'b0;
    wdt_sleep_to = 1'b0;
  endtask

  task automatic pin_pulse(input int low_cycles, input bit do_push,
                           input bit first, input string tag);
    @(negedge clk);
    ext_rst_n = 1'b0;
    repeat (low_cycles) @(negedge clk);
    if (do_push) push(exp_len(osc_mode, first), first, tag);
    ext_rst_n = 1'b1;
  endtask

  task automatic wait_rel(input string tag);
    int n;
    n = 0;
    while (core_rst !== 1'b0 && n < 500) begin
      @(negedge clk);
      n++;
    end
    chk(core_rst === 1'b0, tag, "core released", int'(core_rst), 0);
    repeat (2) @(negedge clk);
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    summary();
    $finish;
  end

  initial begin
    // R1 reset state
    repeat (3) @(negedge clk);
    chk(core_rst === 1'b1, "R1", "core_rst in reset", int'(core_rst), 1);
    chk(first_seq === 1'b1, "R1", "first_seq in reset", int'(first_seq), 1);

    // R2 long after power-on even in a quick mode
    push(LONG_T, 1'b1, "R2");
    por_n = 1'b1;
    wait_rel("R2");
    repeat (4) @(negedge clk);
    chk(first_seq === 1'b1, "R10", "first_seq kept after first release", int'(first_seq), 1);

    // R3 / R6 short in internal RC after the first
    osc_mode = 3'd4;
    evt(1'b0, 1'b1, "R6");
    wait_rel("R6");
    // R7 wake, external clock
    osc_mode = 3'd3;
    evt(1'b1, 1'b1, "R7");
    wait_rel("R7");
    // R5 pin, external RC
    osc_mode = 3'd5;
    pin_pulse(4, 1'b1, 1'b0, "R5");
    @(negedge clk);
    chk(core_rst === 1'b1, "R5", "core_rst after pin low", int'(core_rst), 1);
    wait_rel("R5");

    // R3 crystal families take the long delay
    for (int m = 0; m < 3; m++) begin
      osc_mode = 3'(m);
      evt(1'b0, 1'b1, "R3");
      wait_rel("R3");
    end
    // R4 undefined codes
    for (int m = 6; m < 8; m++) begin
      osc_mode = 3'(m);
      evt(1'b1, 1'b1, "R4");
      wait_rel("R4");
    end

    // R8 restart by wake during a short count
    osc_mode = 3'd4;
    evt(1'b0, 1'b0, "R8");
    repeat (3) @(negedge clk);
    evt(1'b1, 1'b1, "R8");
    wait_rel("R8");
    // R8 restart by pin during a long count
    osc_mode = 3'd0;
    evt(1'b0, 1'b0, "R8");
    repeat (10) @(negedge clk);
    pin_pulse(3, 1'b1, 1'b0, "R8");
    wait_rel("R8");

    // R11 mode sampled at load
    osc_mode = 3'd4;
    evt(1'b0, 1'b1, "R11");
    osc_mode = 3'd0;
    wait_rel("R11");
    osc_mode = 3'd1;
    evt(1'b1, 1'b1, "R11");
    osc_mode = 3'd5;
    wait_rel("R11");

    // R9 sparse ticks
    sparse = 1'b1;
    osc_mode = 3'd4;
    evt(1'b0, 1'b1, "R9");
    wait_rel("R9");
    osc_mode = 3'd2;
    evt(1'b1, 1'b1, "R9");
    wait_rel("R9");
    sparse = 1'b0;

    // R1 / R10 second power-on, first period cut short by the pin
    @(negedge clk);
    por_n = 1'b0;
    @(negedge clk);
    chk(core_rst === 1'b1, "R1", "core_rst after power-on drop", int'(core_rst), 1);
    chk(first_seq === 1'b1, "R10", "first_seq restored by power-on", int'(first_seq), 1);
    osc_mode = 3'd4;
    repeat (2) @(negedge clk);
    por_n = 1'b1;
    repeat (12) @(negedge clk);
    pin_pulse(3, 1'b1, 1'b1, "R10");
    wait_rel("R10");
    evt(1'b0, 1'b1, "R10");
    wait_rel("R10");

    repeat (5) @(negedge clk);
    chk(sb_q.size() == 0, "R8", "pending releases left", sb_q.size(), 0);
    summary();
    $finish;
  end

endmodule